// File: doc/BRIEF.md
# Pipeline Cell Address Manager

This block hands out the cell addresses of a circular sample store that takes one new sample on every clock. A write pointer walks around the ring. On each clock it steps to the next cell. When a trigger arrives, the block finds the cell that was written a fixed number of clocks earlier (the trigger latency). It places that cell's index in an index FIFO and marks the cell as reserved. The write pointer then steps over every reserved cell, so a sample that is waiting for readout is never overwritten. When a consumer pops the oldest index, that cell's reservation is released and the cell rejoins the ring.

The latency is captured while reset is held and then stays fixed. The value is forced into the range 1 to the number of cells minus the FIFO depth. This range keeps the requested cell inside the set of cells that are never reserved. When a trigger arrives and the FIFO is full, the trigger is dropped and a one-clock overflow pulse is raised.

Top module: `cell_addr_mgr`

## Requirements
- R1: While reset is asserted, `wr_addr_o` is 0, `fifo_empty_o` is 1, `fifo_full_o` is 0 and `overflow_o` is 0. No cell is reserved.
- R2: When no cell is reserved, `wr_addr_o` advances by one on every clock and wraps from NUM_CELLS-1 to 0.
- R3: A trigger accepted in the clock where `wr_addr_o` shows cell A pushes the index that `wr_addr_o` showed L clocks earlier, where L is the captured latency.
- R4: Indices leave the FIFO in push order. While the FIFO is not empty, `rd_idx_o` shows the oldest index. A pop while not empty removes that index at the next clock edge.
- R5: A pushed index is reserved until it is popped. The write pointer advances to the next cell after the current one that is not reserved. It considers the reservations made and released in that same clock, and it never shows a reserved cell.
- R6: When a trigger arrives while the FIFO already holds FIFO_DEPTH entries, nothing is pushed and `overflow_o` is 1 for exactly the next clock. `overflow_o` is 0 at every other time.
- R7: A pop while the FIFO is empty has no effect. The flags and the write pointer behave as if no pop was requested.
- R8: `latency_i` is sampled only while reset is asserted. Changing it afterwards does not change which cell a trigger selects.
- R9: A sampled latency above NUM_CELLS-FIFO_DEPTH is used as NUM_CELLS-FIFO_DEPTH, and a latency of 0 is used as 1.
- R10: `fifo_empty_o` is 1 exactly when the FIFO holds no entry, and `fifo_full_o` is 1 exactly when it holds FIFO_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cell is written per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the latency is captured while it is low |
| trig_i | input | 1 | Trigger request, one per clock |
| latency_i | input | $clog2(NUM_CELLS) | Trigger latency in clocks |
| pop_i | input | 1 | Removes the oldest queued index |
| wr_addr_o | output | $clog2(NUM_CELLS) | Cell written in this clock |
| rd_idx_o | output | $clog2(NUM_CELLS) | Oldest queued cell index, valid while not empty |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH indices |
| fifo_empty_o | output | 1 | FIFO holds no index |
| overflow_o | output | 1 | One-clock pulse after a dropped trigger |

## Verification
The bench builds the block with NUM_CELLS=24 and FIFO_DEPTH=4, which gives a maximum latency of 20. With these values the pointer wraps after a few dozen clocks, and four back-to-back triggers fill the FIFO, so the overflow and the skipping of reserved cells are exercised many times in a short run. The largest latency also selects a cell written almost one full free-cell loop ago, which is the tightest case for a reserved cell being reached by the pointer. A scoreboard predicts every write address, flag and popped index from the requirements. It is driven through several resets with different latencies and through a pseudo-random stretch of triggers and pops.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // FIFO operation for one clock
    typedef enum logic [1:0] {
        FOP_NONE = 2'b00,
        FOP_PUSH = 2'b01,
        FOP_POP  = 2'b10,
        FOP_BOTH = 2'b11
    } fifo_op_e;

    // Force a raw latency into the legal window 1..max_lat
    function automatic int clamp_latency(input int raw, input int max_lat);
        if (raw > max_lat) return max_lat;
        if (raw < 1)       return 1;
        return raw;
    endfunction

endpackage

// File: rtl/cam_history.sv
module cam_history #(
    parameter int NUM_CELLS = 192,
    parameter int DEPTH     = 160
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_CELLS)-1:0] cur_addr,
    input  logic [$clog2(NUM_CELLS)-1:0] tap,
    output logic [$clog2(NUM_CELLS)-1:0] tap_addr
);
    localparam int IDX_W = $clog2(NUM_CELLS);

    // hist_q[k] holds the address written k+1 clocks ago
    logic [IDX_W-1:0] hist_q [DEPTH];
    logic [IDX_W-1:0] hist_d [DEPTH];

    always_comb begin
        hist_d[0] = cur_addr;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_comb begin
            hist_d[g] = hist_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
        end
    end

    always_comb begin
        tap_addr = hist_q[int'(tap) - 1];
    end

    AST_TAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tap) >= 1) && (int'(tap) <= DEPTH)); // R3

endmodule

// File: rtl/cam_index_fifo.sv
module cam_index_fifo
    import cam_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    fifo_op_e op;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        op    = fifo_op_e'({pop_en, push_en});
        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (push_en) begin
            mem_d[ctl_q.tail] = push_data;
            ctl_d.tail        = ptr_inc(ctl_q.tail);
        end
        if (pop_en) begin
            ctl_d.head = ptr_inc(ctl_q.head);
        end
        case (op)
            FOP_PUSH: ctl_d.count = ctl_q.count + CNT_W'(1);
            FOP_POP:  ctl_d.count = ctl_q.count - CNT_W'(1);
            default:  ctl_d.count = ctl_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign head_data = mem_q[ctl_q.head];
    assign full      = (ctl_q.count == CNT_W'(DEPTH));
    assign empty     = (ctl_q.count == '0);

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_en); // R6
    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop_en); // R7
    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |=> (ctl_q.count == $past(ctl_q.count) + CNT_W'(1))); // R10
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en == pop_en) |=> $stable(ctl_q.count)); // R10

endmodule

// File: rtl/cam_wptr.sv
module cam_wptr #(
    parameter int NUM_CELLS = 192
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en,
    input  logic [$clog2(NUM_CELLS)-1:0] set_idx,
    input  logic                         clr_en,
    input  logic [$clog2(NUM_CELLS)-1:0] clr_idx,
    output logic [$clog2(NUM_CELLS)-1:0] wr_addr
);
    localparam int IDX_W = $clog2(NUM_CELLS);

    typedef struct packed {
        logic [IDX_W-1:0]     wr;
        logic [NUM_CELLS-1:0] rsv;
    } wp_t;

    wp_t  st_q, st_d;
    logic found;

    always_comb begin
        st_d = st_q;
        // release first, then reserve: both apply before the pointer search
        if (clr_en) st_d.rsv[clr_idx] = 1'b0;
        if (set_en) st_d.rsv[set_idx] = 1'b1;
        found = 1'b0;
        for (int off = 1; off < NUM_CELLS; off++) begin
            int c;
            c = int'(st_q.wr) + off;
            if (c >= NUM_CELLS) c = c - NUM_CELLS;
            if (!found && !st_d.rsv[c]) begin
                st_d.wr = IDX_W'(c);
                found   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_addr = st_q.wr;

    AST_WR_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rsv[st_q.wr]); // R5
    AST_WR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st_q.wr != $past(st_q.wr))); // R2
    AST_RELEASE_WAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> st_q.rsv[clr_idx]); // R5

endmodule

// File: rtl/cell_addr_mgr.sv
module cell_addr_mgr
    import cam_pkg::*;
#(
    parameter int NUM_CELLS  = 192,
    parameter int FIFO_DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_i,
    input  logic [$clog2(NUM_CELLS)-1:0] latency_i,
    input  logic                         pop_i,
    output logic [$clog2(NUM_CELLS)-1:0] wr_addr_o,
    output logic [$clog2(NUM_CELLS)-1:0] rd_idx_o,
    output logic                         fifo_full_o,
    output logic                         fifo_empty_o,
    output logic                         overflow_o
);
    localparam int IDX_W   = $clog2(NUM_CELLS);
    localparam int MAX_LAT = NUM_CELLS - FIFO_DEPTH;

    typedef struct packed {
        logic [IDX_W-1:0] lat;
        logic             ovf;
    } top_t;

    top_t st_q, st_d;
    logic [IDX_W-1:0] lat_in_c;
    logic [IDX_W-1:0] tap_addr;
    logic             push_ok;
    logic             pop_ok;

    always_comb begin
        lat_in_c = IDX_W'(clamp_latency(int'(latency_i), MAX_LAT));
        push_ok  = trig_i && !fifo_full_o;
        pop_ok   = pop_i && !fifo_empty_o;
        st_d     = st_q;
        st_d.ovf = trig_i && fifo_full_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= lat_in_c;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    cam_history #(
        .NUM_CELLS (NUM_CELLS),
        .DEPTH     (MAX_LAT)
    ) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_addr (wr_addr_o),
        .tap      (st_q.lat),
        .tap_addr (tap_addr)
    );

    cam_index_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .DATA_W (IDX_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_ok),
        .push_data (tap_addr),
        .pop_en    (pop_ok),
        .head_data (rd_idx_o),
        .full      (fifo_full_o),
        .empty     (fifo_empty_o)
    );

    cam_wptr #(
        .NUM_CELLS (NUM_CELLS)
    ) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (push_ok),
        .set_idx (tap_addr),
        .clr_en  (pop_ok),
        .clr_idx (rd_idx_o),
        .wr_addr (wr_addr_o)
    );

    assign overflow_o = st_q.ovf;

    AST_OVF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && fifo_full_o) |=> overflow_o); // R6
    AST_OVF_ONLY_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_i && fifo_full_o) |=> !overflow_o); // R6
    AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.lat)); // R8
    AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.lat) >= 1) && (int'(st_q.lat) <= MAX_LAT)); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full_o && fifo_empty_o)); // R10
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && fifo_empty_o && !trig_i) |=> fifo_empty_o); // R7

endmodule

// File: tb/cell_addr_mgr_tb.sv
module cell_addr_mgr_tb;
    localparam int NC = 24;
    localparam int FD = 4;
    localparam int ML = NC - FD;
    localparam int IW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [IW-1:0] latency_i = '0;
    logic [IW-1:0] wr_addr_o, rd_idx_o;
    logic          fifo_full_o, fifo_empty_o, overflow_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cell_addr_mgr #(.NUM_CELLS(NC), .FIFO_DEPTH(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .latency_i(latency_i),
        .pop_i(pop_i), .wr_addr_o(wr_addr_o), .rd_idx_o(rd_idx_o),
        .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o),
        .overflow_o(overflow_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- scoreboard model ----------------
    int  exp_wr;
    bit  rsv [NC];
    int  hist [$];
    int  expq [$];
    bit  ov_exp;
    int  lat_m;
    int  sz;
    int  idx;
    int  cand;
    bit  full_b;
    bit  found;

    always @(negedge clk) begin
        if (!rst_n) begin
            // R9: clamp rule, R8: only captured here
            lat_m = int'(latency_i);
            if (lat_m > ML) lat_m = ML;
            if (lat_m < 1) lat_m = 1;
            exp_wr = 0; ov_exp = 0;
            hist.delete(); expq.delete();
            for (int i = 0; i < NC; i++) rsv[i] = 0;
            chk(wr_addr_o == '0, "R1 wr_addr", int'(wr_addr_o), 0);
            chk(fifo_empty_o == 1'b1, "R1 empty", int'(fifo_empty_o), 1);
            chk(fifo_full_o == 1'b0, "R1 full", int'(fifo_full_o), 0);
            chk(overflow_o == 1'b0, "R1 overflow", int'(overflow_o), 0);
        end else begin
            sz = expq.size();
            chk(int'(wr_addr_o) == exp_wr, "R2/R5 wr_addr", int'(wr_addr_o), exp_wr);
            chk(fifo_empty_o == (sz == 0), "R10/R7 empty", int'(fifo_empty_o), int'(sz == 0));
            chk(fifo_full_o == (sz == FD), "R10 full", int'(fifo_full_o), int'(sz == FD));
            chk(overflow_o == ov_exp, "R6 overflow", int'(overflow_o), int'(ov_exp));
            if (sz > 0)
                chk(int'(rd_idx_o) == expq[0], "R3/R4/R8/R9 rd_idx", int'(rd_idx_o), expq[0]);
            full_b = (sz == FD);
            if (pop_i && sz > 0) begin
                rsv[expq[0]] = 0;
                void'(expq.pop_front());
            end
            if (trig_i && !full_b && hist.size() >= lat_m) begin
                idx = hist[hist.size() - lat_m];
                expq.push_back(idx);
                rsv[idx] = 1;
            end
            ov_exp = trig_i && full_b;
            hist.push_back(exp_wr);
            if (hist.size() > ML) void'(hist.pop_front());
            found = 0;
            for (int off = 1; off < NC; off++) begin
                cand = (exp_wr + off) % NC;
                if (!found && !rsv[cand]) begin
                    exp_wr = cand;
                    found = 1;
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic cyc(input bit t, input bit p);
        @(posedge clk);
        #2;
        trig_i = t;
        pop_i  = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0);
    endtask

    task automatic do_reset(input int lat);
        @(posedge clk);
        #2;
        rst_n = 1'b0; trig_i = 0; pop_i = 0;
        latency_i = IW'(lat);
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R1, R2: reset state then plain advance with wrap
        do_reset(3);
        idle(ML + 10);
        // R3, R4, R5: isolated triggers and in-order pops
        cyc(1, 0); idle(2); cyc(1, 0); idle(NC + 4);
        cyc(0, 1); idle(1); cyc(0, 1); idle(3);
        // R7: pops while empty
        cyc(0, 1); cyc(0, 1); idle(2);

        // R9: zero latency is used as 1
        do_reset(0);
        idle(ML + 2);
        cyc(1, 0); cyc(1, 0); idle(5);
        cyc(0, 1); cyc(1, 1); cyc(0, 1); cyc(0, 1); idle(3);

        // R9: above range clamps to ML; R6: fill and overflow
        do_reset(31);
        idle(ML + 2);
        for (int i = 0; i < 6; i++) cyc(1, 0);
        idle(2 * NC);          // R5: pointer skips four reserved cells
        cyc(1, 1);             // full: trigger dropped, one pop
        for (int i = 0; i < 5; i++) cyc(0, 1);
        idle(NC);

        // R8: latency change after reset is ignored
        do_reset(5);
        latency_i = IW'(9);
        idle(ML + 2);
        cyc(1, 0); idle(3); cyc(1, 0); idle(4);
        cyc(0, 1); cyc(0, 1); idle(2);

        // mixed traffic
        do_reset(7);
        idle(ML + 2);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] & lfsr[3], lfsr[5] & lfsr[7] & lfsr[1]);
        end
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule